// File: doc/BRIEF.md
# Phase-Angle Triac Firing Controller

This block fires an AC power switch once per half cycle of the mains, using phase-angle control. Each half cycle begins on a zero-crossing event. The first zero-crossing input marks it with a rising edge and the second marks it with a falling edge. When only one zero-crossing signal is wired, the first input stands in for both. After a programmable delay, the block emits a burst of eight square firing pulses. The delay is a count multiplied by a prescale factor.

The half-width of each firing pulse is latched once after reset. The output polarity follows a live input. A three-bit selector routes one event source to a single-cycle interrupt output. The sources are the zero-crossing edges and the start of a firing burst. Edge interrupts follow the synchronized inputs at all times, whether or not a half cycle is in progress.

Top module: `phase_fire_ctrl`

## Requirements
- R1: While reset is held, `fire_o` equals `polarity_i` and `irq_o` is 0.
- R2: Both sync inputs pass through a two-flop synchronizer before edge detection. A half cycle starts on a rising edge of `sync_a_i`. It also starts on a falling edge of the effective second sync signal. That signal is `sync_b_i` when `single_sync_i`=0, and `sync_a_i` when `single_sync_i`=1; in the latter case `sync_b_i` has no effect. A falling edge of `sync_a_i` starts nothing when `single_sync_i`=0.
- R3: Take edge 0 as the first clock edge that samples the new sync level. The firing output first goes active at edge `delay_count_i`*(`prescale_i`+1)+3. A count of 0 gives the shortest delay.
- R4: A burst has exactly 8 active phases. Each active phase and each inactive phase between them lasts exactly W clock cycles, where W is the latched half-width. After the burst the output returns to idle.
- R5: `fire_o` is the internal active level XOR `polarity_i`, so the idle level equals `polarity_i`.
- R6: If W is 0, `fire_o` stays at its idle level. The burst interrupt is still raised at the edge where the burst would have started.
- R7: With `irq_sel_i`=4, `irq_o` is high for exactly one cycle, starting at the edge where the burst starts (the edge named in R3).
- R8: Selector codes: 0 none; 1 `sync_a_i` rising; 2 effective second-sync falling; 3 either `sync_a_i` edge; 4 burst start; 5 to 7 none. An edge interrupt is high for one cycle, starting at edge 2 counted as in R3, whether or not a half cycle is running.
- R9: A sync edge that arrives while a delay or burst is running does not restart or extend it.
- R10: `half_width_i` is captured at the first clock edge after reset is released. Later changes have no effect until the next reset.
- R11: `delay_count_i` and `prescale_i` are sampled at the edge that starts a half cycle. Changes during the delay have no effect on its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_a_i | input | 1 | First zero-crossing input (rising edge starts a half cycle) |
| sync_b_i | input | 1 | Second zero-crossing input (falling edge starts a half cycle) |
| single_sync_i | input | 1 | 1: `sync_a_i` also serves as the second sync signal |
| delay_count_i | input | CNT_W | Firing delay in prescaled ticks |
| prescale_i | input | PRE_W | Prescale value N; one tick is N+1 clocks |
| half_width_i | input | UTP_W | Burst half-width in clocks, captured after reset |
| polarity_i | input | 1 | Inverts the firing output |
| irq_sel_i | input | 3 | Interrupt source selector |
| fire_o | output | 1 | Firing output |
| irq_o | output | 1 | Single-cycle interrupt |

## Verification
The bench runs a zero delay count and a large prescale. A design that sampled the edge one stage late, or counted ticks with an off-by-one, would move the whole burst by a cycle; the per-clock comparison reports that at once. Sync edges are thrown at the block mid-burst, and the count and width inputs are changed mid-run. A design that restarted on those edges, or read the inputs live, would produce more than eight pulses or pulses of the new width. A zero half-width checks that the burst interrupt survives with no output activity. The single-sync sweep checks that the falling edge of the first input starts a half cycle and that the second input is then ignored.

// File: rtl/phase_fire_pkg.sv
package phase_fire_pkg;
  localparam logic [2:0] SEL_NONE   = 3'd0;
  localparam logic [2:0] SEL_A_RISE = 3'd1;
  localparam logic [2:0] SEL_B_FALL = 3'd2;
  localparam logic [2:0] SEL_A_BOTH = 3'd3;
  localparam logic [2:0] SEL_BURST  = 3'd4;

  function automatic logic sel_is_silent(input logic [2:0] sel);
    return (sel == SEL_NONE) || (sel > SEL_BURST);
  endfunction
endpackage

// File: rtl/pf_sync.sv
module pf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[0] <= 1'b0;
        else        chain_q[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[i] <= 1'b0;
        else        chain_q[i] <= chain_q[i-1];
      end
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pf_delay_timer.sv
module pf_delay_timer #(
  parameter int CNT_W = 16,
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [PRE_W-1:0] prescale_i,
  output logic             active_o,
  output logic             expire_o
);
  logic             active_q;
  logic [CNT_W-1:0] rem_q;
  logic [PRE_W-1:0] pre_lat_q;
  logic [PRE_W-1:0] pre_cnt_q;
  logic             tick;

  function automatic logic tick_due(input logic [PRE_W-1:0] cnt, input logic [PRE_W-1:0] lim);
    return cnt == lim;
  endfunction

  assign tick     = tick_due(pre_cnt_q, pre_lat_q);
  assign expire_o = active_q && (rem_q == '0);
  assign active_o = active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      rem_q     <= '0;
      pre_lat_q <= '0;
      pre_cnt_q <= '0;
    end else if (!active_q) begin
      if (start_i) begin
        active_q  <= 1'b1;
        rem_q     <= count_i;
        pre_lat_q <= prescale_i;
        pre_cnt_q <= '0;
      end
    end else if (rem_q == '0) begin
      active_q <= 1'b0;
    end else if (tick) begin
      pre_cnt_q <= '0;
      rem_q     <= rem_q - CNT_W'(1);
    end else begin
      pre_cnt_q <= pre_cnt_q + PRE_W'(1);
    end
  end

  assert_prescale_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |=> $stable(pre_lat_q));
  assert_expire_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |=> !expire_o);
  assert_prescale_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (pre_cnt_q <= pre_lat_q));
endmodule

// File: rtl/pf_pulse_train.sv
module pf_pulse_train #(
  parameter int UTP_W  = 16,
  parameter int PULSES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [UTP_W-1:0] width_i,
  output logic             active_o,
  output logic             level_o
);
  localparam int PHASES = 2 * PULSES;
  localparam int HW     = $clog2(PHASES);
  localparam logic [HW-1:0] LAST_PHASE = HW'(PHASES - 1);

  logic             active_q;
  logic [HW-1:0]    half_q;
  logic [UTP_W-1:0] ph_q;

  function automatic logic phase_end(input logic [UTP_W-1:0] cnt, input logic [UTP_W-1:0] w);
    return cnt == (w - UTP_W'(1));
  endfunction

  function automatic logic phase_drives(input logic [HW-1:0] idx);
    return !idx[0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      half_q   <= '0;
      ph_q     <= '0;
    end else if (!active_q) begin
      if (start_i && (width_i != '0)) begin
        active_q <= 1'b1;
        half_q   <= '0;
        ph_q     <= '0;
      end
    end else if (phase_end(ph_q, width_i)) begin
      ph_q <= '0;
      if (half_q == LAST_PHASE) active_q <= 1'b0;
      else                      half_q   <= half_q + HW'(1);
    end else begin
      ph_q <= ph_q + UTP_W'(1);
    end
  end

  assign active_o = active_q;
  assign level_o  = active_q && phase_drives(half_q);

  assert_phase_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (ph_q < width_i));
  assert_burst_ends_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active_q) |-> ($past(half_q) == LAST_PHASE));
endmodule

// File: rtl/pf_irq_route.sv
module pf_irq_route
  import phase_fire_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sel_i,
  input  logic       a_rise_i,
  input  logic       a_fall_i,
  input  logic       b_fall_i,
  input  logic       burst_i,
  output logic       irq_o
);
  logic pick;
  logic irq_q;

  always_comb begin
    case (sel_i)
      SEL_A_RISE: pick = a_rise_i;
      SEL_B_FALL: pick = b_fall_i;
      SEL_A_BOTH: pick = a_rise_i | a_fall_i;
      SEL_BURST:  pick = burst_i;
      default:    pick = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= pick;
  end

  assign irq_o = irq_q;

  assert_silent_codes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sel_is_silent(sel_i) |=> !irq_o);
  assert_burst_irq_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    burst_i |=> !burst_i);
endmodule

// File: rtl/phase_fire_ctrl.sv
module phase_fire_ctrl
  import phase_fire_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int PRE_W       = 8,
  parameter int UTP_W       = 16,
  parameter int PULSES      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_a_i,
  input  logic             sync_b_i,
  input  logic             single_sync_i,
  input  logic [CNT_W-1:0] delay_count_i,
  input  logic [PRE_W-1:0] prescale_i,
  input  logic [UTP_W-1:0] half_width_i,
  input  logic             polarity_i,
  input  logic [2:0]       irq_sel_i,
  output logic             fire_o,
  output logic             irq_o
);
  logic a_lvl, b_lvl, a_prev_q, b_prev_q;
  logic a_rise, a_fall, b_fall, eff_b_fall;
  logic start_raw, start_ok, busy;
  logic dly_active, expire;
  logic trn_active, trn_level;
  logic [UTP_W-1:0] utp_q;
  logic utp_loaded_q;

  pf_sync #(.STAGES(SYNC_STAGES)) u_sync_a (
    .clk(clk), .rst_n(rst_n), .d_i(sync_a_i), .q_o(a_lvl));
  pf_sync #(.STAGES(SYNC_STAGES)) u_sync_b (
    .clk(clk), .rst_n(rst_n), .d_i(sync_b_i), .q_o(b_lvl));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_prev_q <= 1'b0;
      b_prev_q <= 1'b0;
    end else begin
      a_prev_q <= a_lvl;
      b_prev_q <= b_lvl;
    end
  end

  assign a_rise     = a_lvl & ~a_prev_q;
  assign a_fall     = ~a_lvl & a_prev_q;
  assign b_fall     = ~b_lvl & b_prev_q;
  assign eff_b_fall = single_sync_i ? a_fall : b_fall;
  assign start_raw  = a_rise | eff_b_fall;
  assign busy       = dly_active | trn_active;
  assign start_ok   = start_raw & ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      utp_q        <= '0;
      utp_loaded_q <= 1'b0;
    end else if (!utp_loaded_q) begin
      utp_q        <= half_width_i;
      utp_loaded_q <= 1'b1;
    end
  end

  pf_delay_timer #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_delay (
    .clk(clk), .rst_n(rst_n), .start_i(start_ok),
    .count_i(delay_count_i), .prescale_i(prescale_i),
    .active_o(dly_active), .expire_o(expire));

  pf_pulse_train #(.UTP_W(UTP_W), .PULSES(PULSES)) u_train (
    .clk(clk), .rst_n(rst_n), .start_i(expire), .width_i(utp_q),
    .active_o(trn_active), .level_o(trn_level));

  pf_irq_route u_irq (
    .clk(clk), .rst_n(rst_n), .sel_i(irq_sel_i),
    .a_rise_i(a_rise), .a_fall_i(a_fall), .b_fall_i(eff_b_fall),
    .burst_i(expire), .irq_o(irq_o));

  assign fire_o = trn_level ^ polarity_i;

  assert_width_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    utp_loaded_q |=> $stable(utp_q));
  assert_busy_ignores_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (trn_active && start_raw) |=> !dly_active);
  assert_zero_width_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (utp_q == '0) |-> !trn_active);
  assert_idle_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!dly_active && !trn_active) |-> (fire_o == polarity_i));
  assert_stages_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(dly_active && trn_active));
endmodule

// File: tb/phase_fire_ctrl_tb_top.sv
`timescale 1ns/1ps
module phase_fire_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_a = 1'b0, sync_b = 1'b0, single = 1'b0, pol = 1'b0;
  logic [15:0] dcount = 16'd5;
  logic [7:0]  presc = 8'd2;
  logic [15:0] hwidth = 16'd3;
  logic [2:0]  sel = 3'd4;
  logic fire, irq;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  phase_fire_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .sync_a_i(sync_a), .sync_b_i(sync_b),
    .single_sync_i(single), .delay_count_i(dcount), .prescale_i(presc),
    .half_width_i(hwidth), .polarity_i(pol), .irq_sel_i(sel),
    .fire_o(fire), .irq_o(irq));

  // behavioural reference: schedule of the current half cycle in edge numbers
  int x = 0, e = -100000, e1 = -100000, endx = -100000, utp_m = 0;
  bit loaded = 1'b0, mlevel = 1'b0, mirq = 1'b0;
  bit qa[$], qb[$];

  always @(posedge clk) begin
    bit ar, af, bf, pe, sr, busy;
    x++;
    if (!rst_n) begin
      qa = '{0, 0, 0}; qb = '{0, 0, 0};
      loaded = 0; e = -100000; e1 = -100000; endx = -100000;
      mlevel = 0; mirq = 0; utp_m = 0;
    end else begin
      ar = qa[1] && !qa[0];
      af = !qa[1] && qa[0];
      bf = !qb[1] && qb[0];
      if (single) bf = af;
      pe = (x == e1);
      case (sel)
        3'd1: mirq = ar;
        3'd2: mirq = bf;
        3'd3: mirq = ar || af;
        3'd4: mirq = pe;
        default: mirq = 0;
      endcase
      if (!loaded) begin utp_m = int'(hwidth); loaded = 1; end
      busy = (x - 1 >= e) && (x - 1 < endx);
      sr = ar || bf;
      if (sr && !busy) begin
        e = x;
        e1 = x + int'(dcount) * (int'(presc) + 1) + 1;
        endx = (utp_m > 0) ? e1 + 16 * utp_m : e1;
      end
      mlevel = (utp_m > 0) && (x >= e1) && (x < endx) && ((((x - e1) / utp_m) % 2) == 0);
      qa.push_back(sync_a); void'(qa.pop_front());
      qb.push_back(sync_b); void'(qb.pop_front());
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // per-clock comparison and burst measurement
  int pulses = 0, irq_cnt = 0, run = 0, last_run = 0;
  bit act_prev = 1'b0;
  always @(negedge clk) begin
    bit act;
    if (rst_n && !done) begin
      check(fire === (mlevel ^ pol), cur_req, "fire_o", int'(fire), int'(mlevel ^ pol));
      check(irq === mirq, cur_req, "irq_o", int'(irq), int'(mirq));
      act = fire ^ pol;
      if (act && !act_prev) pulses++;
      if (act) run++;
      else if (run > 0) begin last_run = run; run = 0; end
      if (irq) irq_cnt++;
      act_prev = act;
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic clr();
    pulses = 0; irq_cnt = 0; run = 0; last_run = 0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(4);
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000 && !done) begin
      done = 1;
      failures++; checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", wd, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset levels, both polarities
    step(2);
    check(fire === 1'b0, "R1", "fire_o in reset", int'(fire), 0);
    check(irq === 1'b0, "R1", "irq_o in reset", int'(irq), 0);
    pol = 1'b1; step(1);
    check(fire === 1'b1, "R1", "fire_o in reset pol=1", int'(fire), 1);
    pol = 1'b0; step(1);
    rst_n = 1'b1;
    step(5);

    // R3 / R4 / R7: rising edge of first input
    cur_req = "R3"; clr();
    sync_b = 1'b1; sync_a = 1'b1; step(150);
    check(pulses == 8, "R4", "pulse count", pulses, 8);
    check(last_run == 3, "R4", "active phase width", last_run, 3);
    check(irq_cnt == 1, "R7", "burst irq count", irq_cnt, 1);

    // R2: falling edge of second input starts, falling first input does not
    cur_req = "R2"; clr();
    sync_b = 1'b0; step(150);
    check(pulses == 8, "R2", "pulses after second-input fall", pulses, 8);
    clr(); sync_a = 1'b0; step(100);
    check(pulses == 0, "R2", "pulses after first-input fall", pulses, 0);

    // R3: zero count with large prescale
    cur_req = "R3"; clr();
    dcount = 16'd0; presc = 8'd7; sync_a = 1'b1; step(80);
    check(pulses == 8, "R3", "pulses at zero count", pulses, 8);
    sync_a = 1'b0; sync_b = 1'b1; step(20);

    // R11: count and prescale change during the delay
    cur_req = "R11"; clr();
    dcount = 16'd10; presc = 8'd3; sync_b = 1'b0; step(5);
    dcount = 16'd1; presc = 8'd0; step(200);
    check(pulses == 8, "R11", "pulses with inputs changed mid-delay", pulses, 8);
    sync_b = 1'b1; step(10);

    // R9: edges during the burst
    cur_req = "R9"; clr();
    dcount = 16'd2; presc = 8'd1; sync_a = 1'b1; step(20);
    sync_a = 1'b0; step(3); sync_b = 1'b0; step(100);
    check(pulses == 8, "R9", "pulses with edges during burst", pulses, 8);
    check(irq_cnt == 1, "R9", "burst irq count", irq_cnt, 1);
    sync_b = 1'b1; step(10);

    // R5: inverted polarity
    cur_req = "R5"; clr();
    pol = 1'b1; step(2);
    check(fire === 1'b1, "R5", "idle level pol=1", int'(fire), 1);
    sync_a = 1'b1; step(100);
    check(pulses == 8, "R5", "inverted pulses", pulses, 8);
    sync_a = 1'b0; step(10); pol = 1'b0; step(2);

    // R8: every selector code
    cur_req = "R8";
    for (int s = 0; s < 8; s++) begin
      int expct;
      sel = 3'(s); step(1); clr();
      sync_a = 1'b1; step(120); sync_a = 1'b0; step(120);
      sync_b = 1'b0; step(120); sync_b = 1'b1; step(120);
      expct = (s == 1 || s == 2) ? 1 : (s == 3 || s == 4) ? 2 : 0;
      check(irq_cnt == expct, "R8", $sformatf("irq count for sel %0d", s), irq_cnt, expct);
    end

    // R2: single-sync mode
    cur_req = "R2"; sel = 3'd4; single = 1'b1; step(2); clr();
    sync_a = 1'b1; step(120); sync_a = 1'b0; step(120);
    check(pulses == 16, "R2", "single-sync pulses", pulses, 16);
    check(irq_cnt == 2, "R2", "single-sync burst irqs", irq_cnt, 2);
    clr(); sync_b = 1'b0; step(120); sync_b = 1'b1; step(120);
    check(pulses == 0, "R2", "second input ignored in single-sync", pulses, 0);
    single = 1'b0; step(2);

    // R10: width change while running is ignored, then applies after reset
    cur_req = "R10"; clr();
    hwidth = 16'd7; sync_a = 1'b1; step(120);
    check(last_run == 3, "R10", "width before reset", last_run, 3);
    sync_a = 1'b0; sync_b = 1'b1; step(10);
    do_reset(); clr();
    sync_a = 1'b1; step(200);
    check(last_run == 7, "R10", "width after reset", last_run, 7);
    check(pulses == 8, "R10", "pulse count after reset", pulses, 8);
    sync_a = 1'b0; step(20);

    // R6: zero width
    cur_req = "R6"; hwidth = 16'd0; do_reset(); clr();
    sync_a = 1'b1; step(100);
    check(pulses == 0, "R6", "pulses at zero width", pulses, 0);
    check(irq_cnt == 1, "R6", "burst irq at zero width", irq_cnt, 1);
    sync_a = 1'b0; step(10);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule